// File: doc/BRIEF.md
# On-Screen-Display Pixel Color Compositor

This block forms the final dot of an on-screen-display overlay. On every dot clock it receives, for the current screen position, a coverage flag and a 4-bit color code for each of seven stacked layers: sprite, sprite outline, character glyph, character outline, character background, line background and screen background. It applies the global and per-line enables, drops a character background whose code is zero, and limits character outlines according to the outline mode. It then picks the topmost layer that is still present.

The chosen code and a display-period flag leave the block through one register stage. Each output has its own polarity select. Font fetch, scaling and shaded-frame geometry happen upstream, and their results arrive here only as coverage flags. The character background style (none, solid, sunken, raised) also comes from upstream.

Top module: `osd_pixel_compositor`

## Requirements
- R1: Layer priority, highest first: sprite, sprite outline, character glyph, character outline, character background, line background, screen background.
- R2: When no layer is present, the raw color is 0 and the raw display-period flag is 0.
- R3: A character background is present only if its coverage flag is set, its style is not none (style code 00), and its color code is not 0. A code of 0 lets the next lower layer show.
- R4: With `disp_on` low, the character glyph, character outline, character background and line background layers are all absent.
- R5: With `row_chr_on` low, the glyph, character outline and character background layers are absent. The line background is unaffected.
- R6: `spr_on` gates the sprite and sprite outline layers. `scr_on` gates the screen background, which covers every dot when enabled.
- R7: `trim_mode` decides whether the character outline may show. 00 means never. 11 means always. 01 means only when the background style is none (00). 10 means only when the background style is none (00) or solid (01). Styles 10 (sunken) and 11 (raised) are shaded.
- R8: `color_inv` = 1 inverts all four bits of `color_o`, including the idle code. A value of 0 passes the code unchanged.
- R9: `period_inv` = 1 inverts `period_o`. A value of 0 passes the flag unchanged.
- R10: Outputs change one dot clock after the inputs that cause them. While `rst_n` is low at a clock edge, both outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spr_on | input | 1 | Global sprite enable |
| scr_on | input | 1 | Global screen-background enable |
| disp_on | input | 1 | Global character/line display enable |
| row_chr_on | input | 1 | Per-line character output enable |
| trim_mode | input | 2 | Character outline mode |
| bg_style | input | 2 | Character background style |
| color_inv | input | 1 | Color output polarity select |
| period_inv | input | 1 | Display-period polarity select |
| spr_hit | input | 1 | Sprite covers this dot |
| spr_color | input | 4 | Sprite color |
| spr_trim_hit | input | 1 | Sprite outline covers this dot |
| spr_trim_color | input | 4 | Sprite outline color |
| chr_hit | input | 1 | Character glyph covers this dot |
| chr_color | input | 4 | Glyph color |
| chr_trim_hit | input | 1 | Character outline covers this dot |
| chr_trim_color | input | 4 | Character outline color |
| cbg_hit | input | 1 | Character background covers this dot |
| cbg_color | input | 4 | Character background color (0 = transparent) |
| lbg_hit | input | 1 | Line background covers this dot |
| lbg_color | input | 4 | Line background color |
| scr_color | input | 4 | Screen background color |
| color_o | output | 4 | Registered color code after polarity |
| period_o | output | 1 | Registered display-period flag after polarity |

## Verification
The bench goes after adjacent priority pairs. A swapped pair would show the lower layer's color where two layers overlap.

It drives a character background with code 0 over a line background. A design that ignored transparency would output 0 there instead of the line color.

The outline modes 01 and 10 are each tried with solid and shaded styles. A decoder that mixed up the two modes would show or hide the outline on the wrong style. The per-line enable is cleared while a line background is present, and a design that gated too much would drop to the screen color.

The bench also checks polarity on idle dots, where a missed inversion leaves 0 instead of 1111. Latency is checked by sampling before and after the edge.

// File: rtl/osd_mix_pkg.sv
// Package: shared widths, layer record and mode encodings for the compositor.
// Assumes a 4-bit color code; layer index 0 is the highest priority.
package osd_mix_pkg;
    localparam int COLOR_W    = 4;
    localparam int NUM_LAYERS = 7;
    localparam int IDX_W      = $clog2(NUM_LAYERS);

    typedef logic [COLOR_W-1:0] color_t;

    typedef struct packed {
        logic   act;
        color_t col;
    } layer_t;

    typedef enum logic [1:0] {
        BG_NONE   = 2'b00,
        BG_SOLID  = 2'b01,
        BG_SUNKEN = 2'b10,
        BG_RAISED = 2'b11
    } bg_style_e;

    typedef enum logic [1:0] {
        TRIM_NEVER      = 2'b00,
        TRIM_PLAIN      = 2'b01,
        TRIM_PLAIN_FLAT = 2'b10,
        TRIM_ALWAYS     = 2'b11
    } trim_mode_e;
endpackage

// File: rtl/osd_layer_gate.sv
// Module: applies global/per-line enables, transparency and outline mode,
// producing one presence flag and color per layer in priority order.
// Assumes purely combinational use within one dot clock.
module osd_layer_gate
    import osd_mix_pkg::*;
(
    input  logic                       spr_on,
    input  logic                       scr_on,
    input  logic                       disp_on,
    input  logic                       row_chr_on,
    input  logic [1:0]                 trim_mode,
    input  logic [1:0]                 bg_style,
    input  logic                       spr_hit,
    input  color_t                     spr_color,
    input  logic                       spr_trim_hit,
    input  color_t                     spr_trim_color,
    input  logic                       chr_hit,
    input  color_t                     chr_color,
    input  logic                       chr_trim_hit,
    input  color_t                     chr_trim_color,
    input  logic                       cbg_hit,
    input  color_t                     cbg_color,
    input  logic                       lbg_hit,
    input  color_t                     lbg_color,
    input  color_t                     scr_color,
    output layer_t [NUM_LAYERS-1:0]    layers_o
);
    logic chr_group_on;
    logic trim_allowed;
    logic cbg_opaque;

    // Purpose: group enables for character-related layers.
    always_comb chr_group_on = disp_on && row_chr_on;

    // Purpose: decide whether the character outline may show for this style.
    always_comb begin
        unique case (trim_mode_e'(trim_mode))
            TRIM_NEVER:      trim_allowed = 1'b0;
            TRIM_PLAIN:      trim_allowed = (bg_style == BG_NONE);
            TRIM_PLAIN_FLAT: trim_allowed = (bg_style == BG_NONE) || (bg_style == BG_SOLID);
            default:         trim_allowed = 1'b1;
        endcase
    end

    // Purpose: a character background needs a style and a nonzero code.
    always_comb cbg_opaque = (bg_style != BG_NONE) && (cbg_color != '0);

    // Purpose: assemble layers, index 0 on top.
    always_comb begin
        layers_o[0] = '{act: spr_on && spr_hit,                     col: spr_color};
        layers_o[1] = '{act: spr_on && spr_trim_hit,                col: spr_trim_color};
        layers_o[2] = '{act: chr_group_on && chr_hit,               col: chr_color};
        layers_o[3] = '{act: chr_group_on && trim_allowed && chr_trim_hit, col: chr_trim_color};
        layers_o[4] = '{act: chr_group_on && cbg_hit && cbg_opaque, col: cbg_color};
        layers_o[5] = '{act: disp_on && lbg_hit,                    col: lbg_color};
        layers_o[6] = '{act: scr_on,                                col: scr_color};
    end
endmodule

// File: rtl/osd_priority_sel.sv
// Module: fixed-priority picker over N layers; lowest index wins.
// Assumes layers arrive already gated; outputs 0 and no hit when none present.
module osd_priority_sel
    import osd_mix_pkg::*;
#(
    parameter int N = NUM_LAYERS
) (
    input  layer_t [N-1:0] layers_i,
    output color_t         color_o,
    output logic           any_o
);
    // Purpose: scan from the bottom so higher layers override lower ones.
    always_comb begin
        color_o = '0;
        any_o   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (layers_i[i].act) begin
                color_o = layers_i[i].col;
                any_o   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/osd_out_stage.sv
// Module: output register with per-output polarity.
// Assumes synchronous active-low reset clearing both outputs to 0.
module osd_out_stage
    import osd_mix_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   color_inv,
    input  logic   period_inv,
    input  color_t color_i,
    input  logic   any_i,
    output color_t color_o,
    output logic   period_o
);
    // Purpose: register the chosen dot with polarity applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color_o  <= '0;
            period_o <= 1'b0;
        end else begin
            color_o  <= color_i ^ {COLOR_W{color_inv}};
            period_o <= any_i ^ period_inv;
        end
    end
endmodule

// File: rtl/osd_pixel_compositor.sv
// Module: top of the on-screen-display dot compositor.
// Gates layers, picks the topmost, registers the result (one-cycle latency).
// Assumes all inputs are synchronous to the dot clock.
module osd_pixel_compositor
    import osd_mix_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spr_on,
    input  logic               scr_on,
    input  logic               disp_on,
    input  logic               row_chr_on,
    input  logic [1:0]         trim_mode,
    input  logic [1:0]         bg_style,
    input  logic               color_inv,
    input  logic               period_inv,
    input  logic               spr_hit,
    input  logic [COLOR_W-1:0] spr_color,
    input  logic               spr_trim_hit,
    input  logic [COLOR_W-1:0] spr_trim_color,
    input  logic               chr_hit,
    input  logic [COLOR_W-1:0] chr_color,
    input  logic               chr_trim_hit,
    input  logic [COLOR_W-1:0] chr_trim_color,
    input  logic               cbg_hit,
    input  logic [COLOR_W-1:0] cbg_color,
    input  logic               lbg_hit,
    input  logic [COLOR_W-1:0] lbg_color,
    input  logic [COLOR_W-1:0] scr_color,
    output logic [COLOR_W-1:0] color_o,
    output logic               period_o
);
    layer_t [NUM_LAYERS-1:0] layers;
    color_t                  pick_color;
    logic                    pick_any;

    osd_layer_gate i_gate (
        .spr_on         (spr_on),
        .scr_on         (scr_on),
        .disp_on        (disp_on),
        .row_chr_on     (row_chr_on),
        .trim_mode      (trim_mode),
        .bg_style       (bg_style),
        .spr_hit        (spr_hit),
        .spr_color      (spr_color),
        .spr_trim_hit   (spr_trim_hit),
        .spr_trim_color (spr_trim_color),
        .chr_hit        (chr_hit),
        .chr_color      (chr_color),
        .chr_trim_hit   (chr_trim_hit),
        .chr_trim_color (chr_trim_color),
        .cbg_hit        (cbg_hit),
        .cbg_color      (cbg_color),
        .lbg_hit        (lbg_hit),
        .lbg_color      (lbg_color),
        .scr_color      (scr_color),
        .layers_o       (layers)
    );

    osd_priority_sel #(.N(NUM_LAYERS)) i_sel (
        .layers_i (layers),
        .color_o  (pick_color),
        .any_o    (pick_any)
    );

    osd_out_stage i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .color_inv  (color_inv),
        .period_inv (period_inv),
        .color_i    (pick_color),
        .any_i      (pick_any),
        .color_o    (color_o),
        .period_o   (period_o)
    );
endmodule

// File: rtl/osd_pixel_compositor_chk.sv
// Checker: temporal properties on the compositor ports, bound to the top.
module osd_pixel_compositor_chk
    import osd_mix_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               spr_on,
    input logic               scr_on,
    input logic               disp_on,
    input logic               row_chr_on,
    input logic [1:0]         trim_mode,
    input logic [1:0]         bg_style,
    input logic               color_inv,
    input logic               period_inv,
    input logic               spr_hit,
    input logic [COLOR_W-1:0] spr_color,
    input logic               spr_trim_hit,
    input logic [COLOR_W-1:0] spr_trim_color,
    input logic               chr_hit,
    input logic [COLOR_W-1:0] chr_color,
    input logic               chr_trim_hit,
    input logic [COLOR_W-1:0] chr_trim_color,
    input logic               cbg_hit,
    input logic [COLOR_W-1:0] cbg_color,
    input logic               lbg_hit,
    input logic [COLOR_W-1:0] lbg_color,
    input logic [COLOR_W-1:0] scr_color,
    input logic [COLOR_W-1:0] color_o,
    input logic               period_o
);
    logic rst_seen;

    // Purpose: remember that the previous edge had reset asserted.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R10: outputs are cleared one edge after reset.
    always_ff @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            a_r10_reset_clears: assert (color_o == '0 && period_o == 1'b0)
                else $error("a_r10_reset_clears");
        end
    end

    // R1/R6: an enabled sprite dot always wins.
    a_r1_sprite_top: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_on && spr_hit) |=> (color_o == ($past(spr_color) ^ {COLOR_W{$past(color_inv)}})));

    // R2/R4/R6: with all global enables off nothing is displayed.
    a_r2_all_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!spr_on && !scr_on && !disp_on) |=>
        (period_o == $past(period_inv) && color_o == {COLOR_W{$past(color_inv)}}));

    // R6: the screen background makes every dot a display dot.
    a_r6_screen_fills: assert property (@(posedge clk) disable iff (!rst_n)
        scr_on |=> (period_o != $past(period_inv)));

    // R3: a zero-coded character background alone is transparent.
    a_r3_cbg_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cbg_hit && cbg_color == '0 && !spr_on && !scr_on && !chr_hit &&
         !chr_trim_hit && !lbg_hit) |=> (period_o == $past(period_inv)));

    // R5: per-line disable leaves the line background color on top of the screen.
    a_r5_line_bg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on && !row_chr_on && lbg_hit && !spr_on) |=>
        (color_o == ($past(lbg_color) ^ {COLOR_W{$past(color_inv)}})));
endmodule

bind osd_pixel_compositor osd_pixel_compositor_chk i_chk (.*);

// File: tb/test_osd_pixel_compositor.sv
module test_osd_pixel_compositor;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       spr_on, scr_on, disp_on, row_chr_on;
    logic [1:0] trim_mode, bg_style;
    logic       color_inv, period_inv;
    logic       spr_hit, spr_trim_hit, chr_hit, chr_trim_hit, cbg_hit, lbg_hit;
    logic [3:0] spr_color, spr_trim_color, chr_color, chr_trim_color;
    logic [3:0] cbg_color, lbg_color, scr_color;
    logic [3:0] color_o;
    logic       period_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;  // 50 MHz

    osd_pixel_compositor i_osd_pixel_compositor (.*);

    typedef struct packed {
        logic       sp_on, sc_on, d_on, r_on;
        logic [1:0] tm, st;
        logic       sh;  logic [3:0] sc;
        logic       sth; logic [3:0] stc;
        logic       ch;  logic [3:0] cc;
        logic       cth; logic [3:0] ctc;
        logic       bh;  logic [3:0] bc;
        logic       lh;  logic [3:0] lc;
        logic [3:0] scr;
        logic       e_per; logic [3:0] e_col;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        // sp sc d  r  tm     st     sh sc    sth stc   ch cc    cth ctc   bh bc    lh lc    scr   per col
        '{0,0,0,0,2'b00,2'b00, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 4'h0, 0,4'h0}, // R2 idle
        '{0,1,0,0,2'b00,2'b00, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 4'h5, 1,4'h5}, // R6 screen
        '{0,1,1,1,2'b00,2'b00, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'h6, 4'h5, 1,4'h6}, // R1 line>screen
        '{0,1,1,1,2'b00,2'b01, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'h7, 1,4'h6, 4'h5, 1,4'h7}, // R1 cbg>line
        '{0,1,1,1,2'b00,2'b01, 0,4'h0, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'h0, 1,4'h6, 4'h5, 1,4'h6}, // R3 transparent
        '{0,1,1,1,2'b00,2'b01, 0,4'h0, 0,4'h0, 1,4'h9, 0,4'h0, 1,4'h7, 1,4'h6, 4'h5, 1,4'h9}, // R1 glyph>cbg
        '{0,1,1,1,2'b11,2'b01, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'hA, 1,4'h7, 1,4'h6, 4'h5, 1,4'hA}, // R7 mode 11
        '{0,1,1,1,2'b01,2'b01, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'hA, 1,4'h7, 1,4'h6, 4'h5, 1,4'h7}, // R7 mode 01 solid
        '{0,1,1,1,2'b10,2'b01, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'hA, 1,4'h7, 1,4'h6, 4'h5, 1,4'hA}, // R7 mode 10 solid
        '{0,1,1,1,2'b10,2'b10, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'hA, 1,4'h7, 1,4'h6, 4'h5, 1,4'h7}, // R7 mode 10 sunken
        '{0,1,1,1,2'b01,2'b00, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'hA, 1,4'h7, 1,4'h6, 4'h5, 1,4'hA}, // R7 mode 01 none
        '{0,1,1,1,2'b00,2'b00, 0,4'h0, 0,4'h0, 0,4'h0, 1,4'hA, 0,4'h0, 1,4'h6, 4'h5, 1,4'h6}, // R7 mode 00
        '{1,1,1,1,2'b00,2'b00, 1,4'h3, 1,4'hC, 1,4'h9, 0,4'h0, 0,4'h0, 0,4'h0, 4'h5, 1,4'h3}, // R1 sprite top
        '{1,1,1,1,2'b00,2'b00, 0,4'h3, 1,4'hC, 1,4'h9, 0,4'h0, 0,4'h0, 0,4'h0, 4'h5, 1,4'hC}, // R1 sprite trim>glyph
        '{0,1,1,1,2'b00,2'b00, 1,4'h3, 1,4'hC, 1,4'h9, 0,4'h0, 0,4'h0, 0,4'h0, 4'h5, 1,4'h9}, // R6 sprite off
        '{0,1,0,1,2'b11,2'b01, 0,4'h0, 0,4'h0, 1,4'h9, 1,4'hA, 1,4'h7, 1,4'h6, 4'h5, 1,4'h5}, // R4 display off
        '{0,1,1,0,2'b11,2'b01, 0,4'h0, 0,4'h0, 1,4'h9, 1,4'hA, 1,4'h7, 1,4'h6, 4'h5, 1,4'h6}, // R5 line chars off
        '{0,0,1,0,2'b11,2'b01, 0,4'h0, 0,4'h0, 1,4'h9, 1,4'hA, 1,4'h7, 0,4'h6, 4'h5, 0,4'h0}  // R5 nothing left
    };

    task automatic drive(input vec_t v);
        {spr_on, scr_on, disp_on, row_chr_on} = {v.sp_on, v.sc_on, v.d_on, v.r_on};
        trim_mode = v.tm; bg_style = v.st;
        spr_hit = v.sh;       spr_color = v.sc;
        spr_trim_hit = v.sth; spr_trim_color = v.stc;
        chr_hit = v.ch;       chr_color = v.cc;
        chr_trim_hit = v.cth; chr_trim_color = v.ctc;
        cbg_hit = v.bh;       cbg_color = v.bc;
        lbg_hit = v.lh;       lbg_color = v.lc;
        scr_color = v.scr;
    endtask

    task automatic check(input string req, input logic [3:0] ec, input logic ep);
        n_checks++;
        if (color_o !== ec || period_o !== ep) begin
            n_fail++;
            $display("FAIL %s: color=%h period=%b expected color=%h period=%b",
                     req, color_o, period_o, ec, ep);
        end
    endtask

    // Reference model built from the requirements (R1..R7), raw polarity.
    function automatic logic [4:0] model(input vec_t v);
        logic chr_ok, trim_ok;
        chr_ok = v.d_on && v.r_on;
        case (v.tm)
            2'b00: trim_ok = 0;
            2'b01: trim_ok = (v.st == 2'b00);
            2'b10: trim_ok = (v.st == 2'b00) || (v.st == 2'b01);
            default: trim_ok = 1;
        endcase
        if (v.sp_on && v.sh)                                 return {1'b1, v.sc};
        if (v.sp_on && v.sth)                                return {1'b1, v.stc};
        if (chr_ok && v.ch)                                  return {1'b1, v.cc};
        if (chr_ok && trim_ok && v.cth)                      return {1'b1, v.ctc};
        if (chr_ok && v.bh && v.st != 2'b00 && v.bc != 4'h0) return {1'b1, v.bc};
        if (v.d_on && v.lh)                                  return {1'b1, v.lc};
        if (v.sc_on)                                         return {1'b1, v.scr};
        return 5'b0;
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t v;
        logic [31:0] lfsr;
        logic [4:0]  exp;
        rst_n = 0; color_inv = 0; period_inv = 0;
        v = TBL[13];
        drive(v);
        repeat (3) @(negedge clk);
        check("R10 reset clears outputs", 4'h0, 1'b0);
        rst_n = 1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            check($sformatf("R1-table row %0d", i), TBL[i].e_col, TBL[i].e_per);
        end

        // R10: latency, output holds before the edge then follows
        @(negedge clk); drive(TBL[1]);
        @(negedge clk); drive(TBL[12]);
        #1 check("R10 old value before edge", 4'h5, 1'b1);
        @(negedge clk); check("R10 new value after edge", 4'h3, 1'b1);

        // R8 / R9 polarity
        @(negedge clk); drive(TBL[0]); color_inv = 1;
        @(negedge clk); check("R8 idle inverted color", 4'hF, 1'b0);
        period_inv = 1;
        @(negedge clk); check("R9 idle inverted period", 4'hF, 1'b1);
        drive(TBL[1]); color_inv = 0;
        @(negedge clk); check("R9 active inverted period", 4'h5, 1'b0);
        color_inv = 1; period_inv = 0;
        @(negedge clk); check("R8 active inverted color", 4'hA, 1'b1);
        color_inv = 0;

        // Model sweep
        lfsr = 32'hACE1_2357;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            v = vec_t'({lfsr, lfsr ^ 32'h5A5A_C3C3});
            color_inv = lfsr[3]; period_inv = lfsr[9];
            drive(v);
            exp = model(v);
            @(negedge clk);
            check("R1 R3 R4 R5 R6 R7 sweep", exp[3:0] ^ {4{lfsr[3]}}, exp[4] ^ lfsr[9]);
        end

        // R10: reset mid-run clears active output
        color_inv = 0; period_inv = 0; drive(TBL[13]);
        @(negedge clk); rst_n = 0;
        @(negedge clk); check("R10 reset mid-run", 4'h0, 1'b0);
        rst_n = 1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule